// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two parallel buses, called A and B, and can move data in either direction. Each direction has its own storage register with its own clock. The A-to-B register samples the A bus and the B-to-A register samples the B bus. Every direction has a source select that picks what drives the far bus: the live value on the opposite bus, or the value held in that direction's register. Every direction also has an output enable. The A-to-B enable is active high. The B-to-A enable is active low.

The pads are split into separate input, output and output-enable vectors, so the block stays synthesizable. The enable vector repeats the decoded enable on every bit, and the pad ring or the testbench resolves each bus. A build parameter selects whether both data paths complement their data or pass it through unchanged. When both directions drive live data, each bus feeds the other. With no other source active, the pair then keeps its last value without using either register.

Top module: `bus_xcvr_reg`

## Requirements
- R1: On every rising edge of `clk_ab_i`, the A-to-B register loads the value on `a_i`, whatever the select and enable inputs are.
- R2: On every rising edge of `clk_ba_i`, the B-to-A register loads the value on `b_i`, whatever the select and enable inputs are.
- R3: All bits of `b_oe_o` equal `en_ab_i` (1 = B driven). All bits of `a_oe_o` equal the inverse of `en_ba_ni` (0 on `en_ba_ni` = A driven).
- R4: `sel_ab_i` = 0 puts live A data on `b_o`. `sel_ab_i` = 1 puts the A-to-B register value on `b_o`.
- R5: `sel_ba_i` = 0 puts live B data on `a_o`. `sel_ba_i` = 1 puts the B-to-A register value on `a_o`.
- R6: With `en_ab_i` = 0 and `en_ba_ni` = 1, neither output-enable vector has any bit set, and both registers still load on their clock edges.
- R7: With `INVERT` = 1, both `a_o` and `b_o` carry the bitwise complement of their selected source. With `INVERT` = 0, they carry the source unchanged.
- R8: When `rst_ni` is low, both registers clear to zero at once, with no clock edge needed.
- R9: While B is driven with live A data, a rising edge on `clk_ba_i` loads the A value into the B-to-A register, so both registers then hold A.
- R10: With both directions enabled and both selects on live data, once every other driver releases, each bus keeps the value it had last.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab_i | input | 1 | Clock of the A-to-B register |
| clk_ba_i | input | 1 | Clock of the B-to-A register |
| rst_ni | input | 1 | Asynchronous active-low reset of both registers |
| a_i | input | WIDTH | Resolved value of bus A |
| b_i | input | WIDTH | Resolved value of bus B |
| en_ab_i | input | 1 | Drive enable toward B, active high |
| en_ba_ni | input | 1 | Drive enable toward A, active low |
| sel_ab_i | input | 1 | Source for B: 0 live A, 1 stored A |
| sel_ba_i | input | 1 | Source for A: 0 live B, 1 stored B |
| a_o | output | WIDTH | Data presented to bus A |
| a_oe_o | output | WIDTH | Per-bit drive enable of bus A |
| b_o | output | WIDTH | Data presented to bus B |
| b_oe_o | output | WIDTH | Per-bit drive enable of bus B |

## Verification
The assertions are sampled on each register clock. On every such edge they check that the register took the bus value seen at the previous edge and that a register is still zero at its first edge after reset. They also check that each output follows its selected source, with the polarity set by `INVERT`, that every bit of each enable vector agrees, and that isolation mode turns both drivers off. Some behaviour only shows up once the bench resolves the two buses against the block's outputs: the bus holding its value with no external driver, and A being stored in both registers. The bench scenarios cover these. The bench also sweeps every control combination against several data patterns on both polarities.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_e;
endpackage

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/xcvr_path_sel.sv
module xcvr_path_sel
  import xcvr_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic [WIDTH-1:0] live_i,
  input  logic [WIDTH-1:0] stored_i,
  input  logic             sel_i,
  output logic [WIDTH-1:0] data_o
);
  src_e             src;
  logic [WIDTH-1:0] picked;

  assign src = src_e'(sel_i);

  always_comb begin
    unique case (src)
      SRC_STORED: picked = stored_i;
      default:    picked = live_i;
    endcase
  end

  if (INVERT) begin : g_inv
    assign data_o = ~picked;
  end else begin : g_pass
    assign data_o = picked;
  end
endmodule

// File: rtl/xcvr_oe_dec.sv
module xcvr_oe_dec #(
  parameter int WIDTH      = 8,
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic             en_i,
  output logic [WIDTH-1:0] oe_o
);
  logic drive;

  if (ACTIVE_LOW) begin : g_low
    assign drive = ~en_i;
  end else begin : g_high
    assign drive = en_i;
  end

  assign oe_o = {WIDTH{drive}};
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             clk_ab_i,
  input  logic             clk_ba_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             en_ab_i,
  input  logic             en_ba_ni,
  input  logic             sel_ab_i,
  input  logic             sel_ba_i,
  output logic [WIDTH-1:0] a_o,
  output logic [WIDTH-1:0] a_oe_o,
  output logic [WIDTH-1:0] b_o,
  output logic [WIDTH-1:0] b_oe_o
);
  logic [WIDTH-1:0] reg_ab_q;
  logic [WIDTH-1:0] reg_ba_q;

  // storage, one per direction, each on its own clock
  xcvr_store_reg #(.WIDTH(WIDTH)) u_reg_ab (
    .clk_i (clk_ab_i),
    .rst_ni(rst_ni),
    .d_i   (a_i),
    .q_o   (reg_ab_q)
  );

  xcvr_store_reg #(.WIDTH(WIDTH)) u_reg_ba (
    .clk_i (clk_ba_i),
    .rst_ni(rst_ni),
    .d_i   (b_i),
    .q_o   (reg_ba_q)
  );

  // source selection toward each bus
  xcvr_path_sel #(.WIDTH(WIDTH), .INVERT(INVERT)) u_sel_b (
    .live_i  (a_i),
    .stored_i(reg_ab_q),
    .sel_i   (sel_ab_i),
    .data_o  (b_o)
  );

  xcvr_path_sel #(.WIDTH(WIDTH), .INVERT(INVERT)) u_sel_a (
    .live_i  (b_i),
    .stored_i(reg_ba_q),
    .sel_i   (sel_ba_i),
    .data_o  (a_o)
  );

  // enables: toward B active high, toward A active low
  xcvr_oe_dec #(.WIDTH(WIDTH), .ACTIVE_LOW(1'b0)) u_oe_b (
    .en_i(en_ab_i),
    .oe_o(b_oe_o)
  );

  xcvr_oe_dec #(.WIDTH(WIDTH), .ACTIVE_LOW(1'b1)) u_oe_a (
    .en_i(en_ba_ni),
    .oe_o(a_oe_o)
  );
endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input logic             clk_ab_i,
  input logic             clk_ba_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             en_ab_i,
  input logic             en_ba_ni,
  input logic             sel_ab_i,
  input logic             sel_ba_i,
  input logic [WIDTH-1:0] a_o,
  input logic [WIDTH-1:0] a_oe_o,
  input logic [WIDTH-1:0] b_o,
  input logic [WIDTH-1:0] b_oe_o,
  input logic [WIDTH-1:0] reg_ab_q,
  input logic [WIDTH-1:0] reg_ba_q
);
  function automatic logic [WIDTH-1:0] xf(input logic [WIDTH-1:0] v);
    return INVERT ? ~v : v;
  endfunction

  logic ab_seen, ba_seen;

  always_ff @(posedge clk_ab_i or negedge rst_ni) begin
    if (!rst_ni) ab_seen <= 1'b0;
    else         ab_seen <= 1'b1;
  end

  always_ff @(posedge clk_ba_i or negedge rst_ni) begin
    if (!rst_ni) ba_seen <= 1'b0;
    else         ba_seen <= 1'b1;
  end

  AST_AB_CAPTURE: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    ab_seen |-> reg_ab_q == $past(a_i)); // R1
  AST_BA_CAPTURE: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    ba_seen |-> reg_ba_q == $past(b_i)); // R2
  AST_AB_RESET: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    !ab_seen |-> reg_ab_q == '0); // R8
  AST_BA_RESET: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    !ba_seen |-> reg_ba_q == '0); // R8
  AST_OE_B_UNIFORM: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    ($countones(b_oe_o) == 0) || ($countones(b_oe_o) == WIDTH)); // R3
  AST_OE_A_UNIFORM: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    ($countones(a_oe_o) == 0) || ($countones(a_oe_o) == WIDTH)); // R3
  AST_B_LIVE: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    !sel_ab_i |-> b_o == xf(a_i)); // R4
  AST_B_STORED: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    sel_ab_i |-> b_o == xf(reg_ab_q)); // R4
  AST_A_LIVE: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    !sel_ba_i |-> a_o == xf(b_i)); // R5
  AST_A_STORED: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    sel_ba_i |-> a_o == xf(reg_ba_q)); // R5
  AST_ISOLATE: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    (!en_ab_i && en_ba_ni) |-> ($countones(a_oe_o) == 0 && $countones(b_oe_o) == 0)); // R6
endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.WIDTH(WIDTH), .INVERT(INVERT)) u_chk (.*);

// File: tb/sim_bus_xcvr_reg.sv
`timescale 1ns/1ps
module sim_bus_xcvr_reg;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic clk_ab = 1'b0, clk_ba = 1'b0, rst_n = 1'b0;
  logic en_ab = 1'b0, en_ba_n = 1'b1, sel_ab = 1'b0, sel_ba = 1'b0;
  logic [W-1:0] a_bus = '0, b_bus = '0;
  logic drv_a = 1'b1, drv_b = 1'b1;
  logic [W-1:0] tb_a = '0, tb_b = '0;

  logic [W-1:0] a_o, a_oe, b_o, b_oe;
  logic [W-1:0] ia_o, ia_oe, ib_o, ib_oe;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  bus_xcvr_reg #(.WIDTH(W), .INVERT(1'b0)) u0 (
    .clk_ab_i(clk_ab), .clk_ba_i(clk_ba), .rst_ni(rst_n),
    .a_i(a_bus), .b_i(b_bus),
    .en_ab_i(en_ab), .en_ba_ni(en_ba_n), .sel_ab_i(sel_ab), .sel_ba_i(sel_ba),
    .a_o(a_o), .a_oe_o(a_oe), .b_o(b_o), .b_oe_o(b_oe)
  );

  bus_xcvr_reg #(.WIDTH(W), .INVERT(1'b1)) u1 (
    .clk_ab_i(clk_ab), .clk_ba_i(clk_ba), .rst_ni(rst_n),
    .a_i(a_bus), .b_i(b_bus),
    .en_ab_i(en_ab), .en_ba_ni(en_ba_n), .sel_ab_i(sel_ab), .sel_ba_i(sel_ba),
    .a_o(ia_o), .a_oe_o(ia_oe), .b_o(ib_o), .b_oe_o(ib_oe)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // wired resolution: external driver wins, then the block, else the bus keeps its value
  task automatic settle();
    for (int k = 0; k < 4; k++) begin
      #1;
      a_bus = drv_a ? tb_a : (a_oe[0] ? a_o : a_bus);
      b_bus = drv_b ? tb_b : (b_oe[0] ? b_o : b_bus);
    end
    #1;
  endtask

  task automatic pulse_ab();
    clk_ab = 1'b1; #1; clk_ab = 1'b0; settle();
  endtask

  task automatic pulse_ba();
    clk_ba = 1'b1; #1; clk_ba = 1'b0; settle();
  endtask

  task automatic set_mode(input logic [3:0] m);
    en_ab = m[0]; en_ba_n = m[1]; sel_ab = m[2]; sel_ba = m[3];
  endtask

  initial begin : watchdog
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [W-1:0] pa, pb, la, lb, eb, ea;
    // reset state, R8
    tb_a = 8'hA5; tb_b = 8'h3C; set_mode(4'b1101);
    settle();
    check("R8 reset stored B", b_o, 8'h00);
    check("R8 reset stored A", a_o, 8'h00);
    check("R8 R7 reset inverted B", ib_o, 8'hFF);
    #3 rst_n = 1'b1; settle();

    // sweep every control combination against several patterns
    for (int i = 0; i < 6; i++) begin
      for (int m = 0; m < 16; m++) begin
        pa = 8'(i * 53 + m * 7 + 1);
        pb = 8'(~(i * 29 + m * 11));
        la = pa ^ 8'h3C;
        lb = 8'(pb + 8'd91);
        drv_a = 1'b1; drv_b = 1'b1; tb_a = pa; tb_b = pb;
        set_mode(4'(m));
        settle();
        pulse_ab(); pulse_ba();
        tb_a = la; tb_b = lb;
        settle();
        eb = sel_ab ? pa : la;
        ea = sel_ba ? pb : lb;
        check(sel_ab ? "R1 R4 R6 stored to B" : "R4 live to B", b_o, eb);
        check(sel_ba ? "R2 R5 R6 stored to A" : "R5 live to A", a_o, ea);
        check("R7 inverted B", ib_o, ~eb);
        check("R7 inverted A", ia_o, ~ea);
        check("R3 R6 B enable", b_oe, {W{en_ab}});
        check("R3 R6 A enable", a_oe, {W{~en_ba_n}});
      end
    end

    // store A in both registers, R9
    drv_a = 1'b1; drv_b = 1'b0; tb_a = 8'hC3;
    set_mode(4'b0011);
    settle();
    check("R9 B carries live A", b_bus, 8'hC3);
    pulse_ab(); pulse_ba();
    en_ab = 1'b0; sel_ab = 1'b1; sel_ba = 1'b1;
    drv_b = 1'b1; tb_a = 8'h00; tb_b = 8'hFF;
    settle();
    check("R9 A-to-B register holds A", b_o, 8'hC3);
    check("R9 B-to-A register holds A", a_o, 8'hC3);

    // bus hold with both directions live, R10
    drv_a = 1'b1; drv_b = 1'b0; tb_a = 8'h96;
    set_mode(4'b0001);
    settle();
    drv_a = 1'b0;
    settle(); settle();
    check("R10 A held", a_bus, 8'h96);
    check("R10 B held", b_bus, 8'h96);
    drv_b = 1'b1; tb_b = 8'h1E;
    settle();
    drv_b = 1'b0;
    settle(); settle();
    check("R10 A follows then holds", a_bus, 8'h1E);
    check("R10 B held after release", b_bus, 8'h1E);

    // asynchronous reset mid-run, R8
    drv_a = 1'b1; drv_b = 1'b1; tb_a = 8'h77; tb_b = 8'h88;
    set_mode(4'b1100);
    settle(); pulse_ab(); pulse_ba();
    check("R1 loaded before reset", b_o, 8'h77);
    rst_n = 1'b0; settle();
    check("R8 A-to-B cleared without clock", b_o, 8'h00);
    check("R8 B-to-A cleared without clock", a_o, 8'h00);
    rst_n = 1'b1; settle();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule